// File: doc/BRIEF.md
# Bit-Addressable GPIO Port Controller

This block is a parameterised port of general-purpose pins (32 by default) behind a small synchronous register bus. Software drives pins through an output latch and a direction register. Each has a plain word register and two atomic aliases: writing a mask to one alias sets those bits, and writing a mask to the other clears them. Every pin also has a configuration word. Bit 0 of that word is the pin's direction bit, so the packed direction register and the configuration words are two views of the same storage. The other bits choose whether the input buffer is connected and which pull resistor applies.

Each cycle the block samples one input bit per pin. The sample is taken from the block's own driven level, from the external level, from the selected pull, or from the value already held, depending on the pin's configuration. The external side of each pin has three states, modelled as a drive-enable and a level: low, high and undriven. When an output pin meets an external driver at the opposite level, the block records a short circuit. It sets a sticky per-pin flag that is cleared by writing one to it, and it pulses an error output for one cycle.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, all packed registers read zero. These are output at byte offset 0x000, output-set at 0x004, output-clear at 0x008, input at 0x00C, direction at 0x010, direction-set at 0x014, direction-clear at 0x018 and error flags at 0x01C. Reading a set or clear alias returns the register it modifies.
- R2: After reset, each pin's configuration word reads 0x2. The word for pin i is at byte offset 0x200 + 4*i. Its layout is bit 0 = direction (1 = output), bit 1 = input disconnect, bits 3:2 = pull.
- R3: Writing the direction register replaces every bit. The direction-set alias ORs the written mask into the register, and the direction-clear alias clears the masked bits. pad_oe_o shows the new value one cycle after the write.
- R4: Bit 0 of pin i's configuration word and bit i of the direction register are the same state. A write through either view is visible in the other.
- R5: While configuration bit 1 is 1, the pin's input bit reads 0. While it is 0, an externally driven level propagates to the input register.
- R6: For a connected input pin that is not externally driven, pull code 01 samples 0 and pull code 11 samples 1. An external driver overrides the pull.
- R7: For a connected input pin that is not externally driven, pull code 00 or 10 keeps the previously sampled bit.
- R8: The output register is written whole, the set alias ORs a mask into it and the clear alias removes the masked bits. pad_out_o shows the latch one cycle after the write.
- R9: A connected pin configured as an output samples the level the block itself drives, regardless of the external level.
- R10: A short circuit sets the pin's bit in the error register. A short circuit is an output pin whose external driver is at the opposite level. The bit stays set after the short circuit ends, and writing 1 to it clears it. A short circuit in the same cycle as the clear wins over the clear. An input pin never raises the flag.
- R11: err_pulse_o is high for exactly one cycle, in the cycle after any pin newly enters a short circuit.
- R12: A read request returns data with rvalid_o one cycle later. Unmapped offsets read 0. Writes to the input register or to unmapped offsets change nothing. Configuration bits above bit 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset, word aligned |
| wdata_i | input | DATA_W | Write data |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | DATA_W | Read data |
| pin_drv_i | input | NUM_PINS | External source drives the pin |
| pin_lvl_i | input | NUM_PINS | Level of the external source |
| pad_oe_o | output | NUM_PINS | Per-pin output enable |
| pad_out_o | output | NUM_PINS | Per-pin driven level |
| err_pulse_o | output | 1 | One-cycle short-circuit pulse |

## Verification
A register write takes effect at the clock edge that accepts it. The pad outputs therefore change in that same cycle, and the input sample reflects the new configuration one edge later. A read returns what the registers held at its own accepting edge. For this reason every bench write is followed by one idle cycle before the next access. A change on the external pins is set up half a cycle before an edge; the input register and the error register capture it at that edge, and a read issued in the following cycle returns it. err_pulse_o is sampled at the falling edge just after the capturing edge, and once more one cycle later to confirm that it falls.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // word indices (byte offset >> 2)
  localparam int unsigned OFS_OUT      = 0;
  localparam int unsigned OFS_OUT_SET  = 1;
  localparam int unsigned OFS_OUT_CLR  = 2;
  localparam int unsigned OFS_IN       = 3;
  localparam int unsigned OFS_DIR      = 4;
  localparam int unsigned OFS_DIR_SET  = 5;
  localparam int unsigned OFS_DIR_CLR  = 6;
  localparam int unsigned OFS_ERR      = 7;
  localparam int unsigned OFS_CFG_BASE = 128;

  typedef enum logic [1:0] {
    PULL_NONE = 2'b00,
    PULL_DOWN = 2'b01,
    PULL_RSVD = 2'b10,
    PULL_UP   = 2'b11
  } pull_e;

  typedef struct packed {
    pull_e pull;   // [3:2]
    logic  disc;   // [1]
    logic  dir;    // [0]
  } pin_cfg_t;

  localparam pin_cfg_t CFG_RESET = '{pull: PULL_NONE, disc: 1'b1, dir: 1'b0};

endpackage

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_port_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  pin_cfg_t cfg_i,
  input  logic     out_lvl_i,
  input  logic     ext_drv_i,
  input  logic     ext_lvl_i,
  output logic     in_o
);

  logic in_q, in_d;

  always_comb begin
    in_d = in_q;
    if (cfg_i.disc) begin
      in_d = 1'b0;
    end else if (cfg_i.dir) begin
      in_d = out_lvl_i;
    end else if (ext_drv_i) begin
      in_d = ext_lvl_i;
    end else begin
      case (cfg_i.pull)
        PULL_UP:   in_d = 1'b1;
        PULL_DOWN: in_d = 1'b0;
        default:   in_d = in_q;  // floating: keep last sample
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_q <= 1'b0;
    else         in_q <= in_d;
  end

  assign in_o = in_q;

endmodule

// File: rtl/gpio_contention_mon.sv
module gpio_contention_mon #(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] oe_i,
  input  logic [NUM_PINS-1:0] out_i,
  input  logic [NUM_PINS-1:0] ext_drv_i,
  input  logic [NUM_PINS-1:0] ext_lvl_i,
  input  logic                clr_we_i,
  input  logic [NUM_PINS-1:0] clr_mask_i,
  output logic [NUM_PINS-1:0] flags_o,
  output logic                pulse_o
);

  logic [NUM_PINS-1:0] short_now, short_q, flags_q, clr_eff;
  logic                pulse_q;

  assign short_now = oe_i & ext_drv_i & (ext_lvl_i ^ out_i);
  assign clr_eff   = clr_we_i ? clr_mask_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      short_q <= '0;
      pulse_q <= 1'b0;
    end else begin
      flags_q <= (flags_q & ~clr_eff) | short_now;  // new short wins over clear
      short_q <= short_now;
      pulse_q <= |(short_now & ~short_q);
    end
  end

  assign flags_o = flags_q;
  assign pulse_o = pulse_q;

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic                rvalid_o,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] pin_drv_i,
  input  logic [NUM_PINS-1:0] pin_lvl_i,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic                err_pulse_o
);

  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam int unsigned IDX_W  = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  localparam logic [WORD_W-1:0] W_OUT     = WORD_W'(OFS_OUT);
  localparam logic [WORD_W-1:0] W_OUT_SET = WORD_W'(OFS_OUT_SET);
  localparam logic [WORD_W-1:0] W_OUT_CLR = WORD_W'(OFS_OUT_CLR);
  localparam logic [WORD_W-1:0] W_IN      = WORD_W'(OFS_IN);
  localparam logic [WORD_W-1:0] W_DIR     = WORD_W'(OFS_DIR);
  localparam logic [WORD_W-1:0] W_DIR_SET = WORD_W'(OFS_DIR_SET);
  localparam logic [WORD_W-1:0] W_DIR_CLR = WORD_W'(OFS_DIR_CLR);
  localparam logic [WORD_W-1:0] W_ERR     = WORD_W'(OFS_ERR);
  localparam logic [WORD_W-1:0] W_CFG     = WORD_W'(OFS_CFG_BASE);
  localparam logic [WORD_W-1:0] W_NPINS   = WORD_W'(NUM_PINS);

  logic [WORD_W-1:0]   word, cfg_off;
  logic                wr, rd, cfg_hit;
  logic [IDX_W-1:0]    cfg_idx;
  logic [NUM_PINS-1:0] wmask;
  logic                unused_addr;

  assign word        = addr_i[ADDR_W-1:2];
  assign unused_addr = ^addr_i[1:0];
  assign wr          = req_i & we_i;
  assign rd          = req_i & ~we_i;
  assign cfg_off     = word - W_CFG;
  assign cfg_hit     = (word >= W_CFG) && (cfg_off < W_NPINS);
  assign cfg_idx     = cfg_off[IDX_W-1:0];
  assign wmask       = wdata_i[NUM_PINS-1:0];

  logic [NUM_PINS-1:0] out_q, out_d;
  logic [NUM_PINS-1:0] dir_vec, dir_d;
  logic [NUM_PINS-1:0] in_vec, err_vec;
  pin_cfg_t            cfg_q [NUM_PINS];

  // output latch
  always_comb begin
    out_d = out_q;
    if (wr) begin
      case (word)
        W_OUT:     out_d = wmask;
        W_OUT_SET: out_d = out_q | wmask;
        W_OUT_CLR: out_d = out_q & ~wmask;
        default:   out_d = out_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else         out_q <= out_d;
  end

  // packed direction view
  always_comb begin
    dir_d = dir_vec;
    if (wr) begin
      case (word)
        W_DIR:     dir_d = wmask;
        W_DIR_SET: dir_d = dir_vec | wmask;
        W_DIR_CLR: dir_d = dir_vec & ~wmask;
        default:   dir_d = dir_vec;
      endcase
    end
  end

  // per-pin config words; dir bit shared with packed view
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign dir_vec[g] = cfg_q[g].dir;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[g] <= CFG_RESET;
      end else if (wr && cfg_hit && (cfg_idx == IDX_W'(g))) begin
        cfg_q[g] <= pin_cfg_t'(wdata_i[3:0]);
      end else begin
        cfg_q[g].dir <= dir_d[g];
      end
    end

    gpio_pin_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cfg_i     (cfg_q[g]),
      .out_lvl_i (out_q[g]),
      .ext_drv_i (pin_drv_i[g]),
      .ext_lvl_i (pin_lvl_i[g]),
      .in_o      (in_vec[g])
    );
  end

  gpio_contention_mon #(.NUM_PINS(NUM_PINS)) u_mon (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .oe_i       (dir_vec),
    .out_i      (out_q),
    .ext_drv_i  (pin_drv_i),
    .ext_lvl_i  (pin_lvl_i),
    .clr_we_i   (wr && (word == W_ERR)),
    .clr_mask_i (wmask),
    .flags_o    (err_vec),
    .pulse_o    (err_pulse_o)
  );

  // read path, one cycle latency
  logic [DATA_W-1:0] rd_mux, rdata_q;
  logic              rvalid_q;

  always_comb begin
    rd_mux = '0;
    case (word)
      W_OUT, W_OUT_SET, W_OUT_CLR: rd_mux[NUM_PINS-1:0] = out_q;
      W_IN:                        rd_mux[NUM_PINS-1:0] = in_vec;
      W_DIR, W_DIR_SET, W_DIR_CLR: rd_mux[NUM_PINS-1:0] = dir_vec;
      W_ERR:                       rd_mux[NUM_PINS-1:0] = err_vec;
      default: if (cfg_hit) rd_mux[3:0] = cfg_q[cfg_idx];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd;
      if (rd) rdata_q <= rd_mux;
    end
  end

  assign rvalid_o  = rvalid_q;
  assign rdata_o   = rdata_q;
  assign pad_oe_o  = dir_vec;
  assign pad_out_o = out_q;

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 12
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [DATA_W-1:0]   wdata_i,
  input logic                rvalid_o,
  input logic [NUM_PINS-1:0] pin_drv_i,
  input logic [NUM_PINS-1:0] pin_lvl_i,
  input logic [NUM_PINS-1:0] pad_oe_o,
  input logic [NUM_PINS-1:0] pad_out_o,
  input logic                err_pulse_o
);

  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0]   word;
  logic [NUM_PINS-1:0] mask, shorted;
  logic                wr, rd;

  assign word    = addr_i[ADDR_W-1:2];
  assign mask    = wdata_i[NUM_PINS-1:0];
  assign wr      = req_i & we_i;
  assign rd      = req_i & ~we_i;
  assign shorted = pad_oe_o & pin_drv_i & (pin_lvl_i ^ pad_out_o);

  a_r3_dir_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && word == WORD_W'(OFS_DIR_SET)) |=> pad_oe_o == ($past(pad_oe_o) | $past(mask)));

  a_r3_dir_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && word == WORD_W'(OFS_DIR_CLR)) |=> pad_oe_o == ($past(pad_oe_o) & ~$past(mask)));

  a_r8_out_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && word == WORD_W'(OFS_OUT_SET)) |=> pad_out_o == ($past(pad_out_o) | $past(mask)));

  a_r8_out_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && word == WORD_W'(OFS_OUT_CLR)) |=> pad_out_o == ($past(pad_out_o) & ~$past(mask)));

  a_r11_short_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|shorted) |=> err_pulse_o);

  a_r12_read_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> rvalid_o);

  a_r12_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> !rvalid_o);

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(
  .NUM_PINS (NUM_PINS),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rvalid_o    (rvalid_o),
  .pin_drv_i   (pin_drv_i),
  .pin_lvl_i   (pin_lvl_i),
  .pad_oe_o    (pad_oe_o),
  .pad_out_o   (pad_out_o),
  .err_pulse_o (err_pulse_o)
);

// File: tb/gpio_port_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_port_ctrl_tb_top;

  localparam int unsigned NP = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0, we_i = 1'b0;
  logic [11:0]   addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic          rvalid_o;
  logic [31:0]   rdata_o;
  logic [NP-1:0] pin_drv_i = '0, pin_lvl_i = '0;
  logic [NP-1:0] pad_oe_o, pad_out_o;
  logic          err_pulse_o;

  always #2.5 clk_i = ~clk_i;

  gpio_port_ctrl #(.NUM_PINS(NP), .DATA_W(32), .ADDR_W(12)) dut_i (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rvalid_o, .rdata_o,
    .pin_drv_i, .pin_lvl_i, .pad_oe_o, .pad_out_o, .err_pulse_o
  );

  localparam logic [11:0] A_OUT = 12'h000, A_OSET = 12'h004, A_OCLR = 12'h008,
                          A_IN  = 12'h00C, A_DIR  = 12'h010, A_DSET = 12'h014,
                          A_DCLR = 12'h018, A_ERR = 12'h01C, A_CFG0 = 12'h200,
                          A_CFG5 = 12'h214, A_CFG31 = 12'h27C;

  int n_chk = 0, n_fail = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i); req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); req_i = 1'b0; we_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk_i); req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i); req_i = 1'b0;
    check("R12 rvalid", {31'd0, rvalid_o}, 32'd1);
    d = rdata_o;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic set_pin0(input logic drv, input logic lvl);
    @(negedge clk_i); pin_drv_i[0] = drv; pin_lvl_i[0] = lvl;
  endtask

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 38;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h000, 32'h0, 32'h0, 8'd1},           // R1
    '{1'b0, 12'h004, 32'h0, 32'h0, 8'd1},           // R1
    '{1'b0, 12'h008, 32'h0, 32'h0, 8'd1},           // R1
    '{1'b0, 12'h00C, 32'h0, 32'h0, 8'd1},           // R1
    '{1'b0, 12'h010, 32'h0, 32'h0, 8'd1},           // R1
    '{1'b0, 12'h014, 32'h0, 32'h0, 8'd1},           // R1
    '{1'b0, 12'h018, 32'h0, 32'h0, 8'd1},           // R1
    '{1'b0, 12'h01C, 32'h0, 32'h0, 8'd1},           // R1
    '{1'b0, 12'h200, 32'h0, 32'h2, 8'd2},           // R2
    '{1'b0, 12'h27C, 32'h0, 32'h2, 8'd2},           // R2
    '{1'b1, 12'h014, 32'h80000001, 32'h0, 8'd3},
    '{1'b0, 12'h010, 32'h0, 32'h80000001, 8'd3},    // R3 set
    '{1'b0, 12'h200, 32'h0, 32'h3, 8'd4},           // R4
    '{1'b0, 12'h27C, 32'h0, 32'h3, 8'd4},           // R4
    '{1'b1, 12'h018, 32'h80000001, 32'h0, 8'd3},
    '{1'b0, 12'h010, 32'h0, 32'h0, 8'd3},           // R3 clear
    '{1'b0, 12'h27C, 32'h0, 32'h2, 8'd4},           // R4
    '{1'b1, 12'h010, 32'h0000F00F, 32'h0, 8'd3},
    '{1'b0, 12'h010, 32'h0, 32'h0000F00F, 8'd3},    // R3 direct
    '{1'b1, 12'h010, 32'h00000100, 32'h0, 8'd3},
    '{1'b0, 12'h018, 32'h0, 32'h00000100, 8'd3},    // R3 replace
    '{1'b1, 12'h214, 32'h00000003, 32'h0, 8'd4},
    '{1'b0, 12'h010, 32'h0, 32'h00000120, 8'd4},    // R4 cfg -> dir
    '{1'b1, 12'h010, 32'h0, 32'h0, 8'd3},
    '{1'b0, 12'h214, 32'h0, 32'h2, 8'd4},           // R4 dir -> cfg, disc kept
    '{1'b1, 12'h000, 32'hA5A5A5A5, 32'h0, 8'd8},
    '{1'b0, 12'h000, 32'h0, 32'hA5A5A5A5, 8'd8},    // R8
    '{1'b1, 12'h004, 32'h0000000F, 32'h0, 8'd8},
    '{1'b0, 12'h008, 32'h0, 32'hA5A5A5AF, 8'd8},    // R8 set
    '{1'b1, 12'h008, 32'hA0000000, 32'h0, 8'd8},
    '{1'b0, 12'h004, 32'h0, 32'h05A5A5AF, 8'd8},    // R8 clear
    '{1'b1, 12'h000, 32'h0, 32'h0, 8'd8},
    '{1'b0, 12'h3F0, 32'h0, 32'h0, 8'd12},          // R12 unmapped
    '{1'b1, 12'h00C, 32'hFFFFFFFF, 32'h0, 8'd12},
    '{1'b0, 12'h00C, 32'h0, 32'h0, 8'd12},          // R12 input read-only
    '{1'b1, 12'h200, 32'hFFFFFFF2, 32'h0, 8'd12},
    '{1'b0, 12'h200, 32'h0, 32'h2, 8'd12},          // R12 upper cfg bits
    '{1'b0, 12'h010, 32'h0, 32'h0, 8'd12}           // R12 dir untouched
  };

  bit done = 1'b0;

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk_i);
    check("R1 pad_oe reset", {{(32-NP){1'b0}}, pad_oe_o}, 32'h0);
    check("R11 pulse reset", {31'd0, err_pulse_o}, 32'h0);
    rst_ni = 1'b1;
    check("R12 rvalid idle", {31'd0, rvalid_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) bus_wr(VECS[i].addr, VECS[i].data);
      else begin
        bus_rd(VECS[i].addr, d);
        check($sformatf("R%0d vec %0d", VECS[i].req, i), d, VECS[i].exp);
      end
    end

    // R5: disconnect blocks the external level
    set_pin0(1'b1, 1'b1);
    rd_chk("R5 disconnected", A_IN, 32'h0);
    bus_wr(A_CFG0, 32'h0);
    rd_chk("R5 connected high", A_IN, 32'h1);
    set_pin0(1'b1, 1'b0);
    rd_chk("R5 connected low", A_IN, 32'h0);

    // R7 / R6: float, pulls, reserved code
    set_pin0(1'b1, 1'b1);
    set_pin0(1'b0, 1'b0);
    rd_chk("R7 float hold 1", A_IN, 32'h1);
    bus_wr(A_CFG0, 32'h4);
    rd_chk("R6 pull-down", A_IN, 32'h0);
    bus_wr(A_CFG0, 32'h0);
    rd_chk("R7 float hold 0", A_IN, 32'h0);
    bus_wr(A_CFG0, 32'hC);
    rd_chk("R6 pull-up", A_IN, 32'h1);
    bus_wr(A_CFG0, 32'h8);
    rd_chk("R7 reserved pull holds", A_IN, 32'h1);
    bus_wr(A_CFG0, 32'hC);
    set_pin0(1'b1, 1'b0);
    rd_chk("R6 driver beats pull-up", A_IN, 32'h0);
    set_pin0(1'b0, 1'b0);

    // R9 / R8: self-stimulation and pad outputs
    bus_wr(A_CFG0, 32'h1);
    check("R8 pad_oe from cfg", {31'd0, pad_oe_o[0]}, 32'h1);
    bus_wr(A_OSET, 32'h1);
    check("R8 pad_out set", {31'd0, pad_out_o[0]}, 32'h1);
    rd_chk("R9 own level 1", A_IN, 32'h1);
    bus_wr(A_OCLR, 32'h1);
    check("R8 pad_out clear", {31'd0, pad_out_o[0]}, 32'h0);
    rd_chk("R9 own level 0", A_IN, 32'h0);

    // R10: input pin facing opposite driver is no short
    bus_wr(A_CFG0, 32'h0);
    bus_wr(A_OSET, 32'h1);
    set_pin0(1'b1, 1'b0);
    rd_chk("R10 input no flag", A_ERR, 32'h0);
    check("R11 no pulse on input", {31'd0, err_pulse_o}, 32'h0);
    set_pin0(1'b0, 1'b0);

    // R10 / R11: short circuit on output pin driving 1
    bus_wr(A_CFG0, 32'h1);
    rd_chk("R10 clean before", A_ERR, 32'h0);
    set_pin0(1'b1, 1'b0);
    @(negedge clk_i);
    check("R11 pulse high", {31'd0, err_pulse_o}, 32'h1);
    @(negedge clk_i);
    check("R11 pulse one cycle", {31'd0, err_pulse_o}, 32'h0);
    rd_chk("R9 own level under short", A_IN, 32'h1);
    rd_chk("R10 flag set", A_ERR, 32'h1);
    bus_wr(A_ERR, 32'h1);
    rd_chk("R10 short beats clear", A_ERR, 32'h1);
    set_pin0(1'b0, 1'b0);
    rd_chk("R10 sticky", A_ERR, 32'h1);
    bus_wr(A_ERR, 32'h1);
    rd_chk("R10 cleared", A_ERR, 32'h0);
    check("R11 no pulse at end", {31'd0, err_pulse_o}, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule